// File: doc/BRIEF.md
# Bus Chip-Select Decoder

This block sits beside a processor bus that has 24-bit byte addresses and asynchronous transfers. It has no clock. It looks at the upper address lines while the active-low address strobe is low, and it drives one active-low chip select per device. It also turns the two byte-lane data strobes and the read/write line into four active-low byte strobes: upper read, lower read, upper write and lower write. The memory devices use these strobes directly. Address line 0 is not on the bus. The byte lane is carried by the upper and lower data strobes.

The decoding style is chosen at elaboration with `FULL_DECODE`.

In full-decode mode, every address line above a device's span must match that device's base. The defaults give three devices:
- a 32 KB ROM at $000000–$007FFF
- a 128 KB RAM at $480000–$49FFFF
- a 32-byte I/O block at $800000–$80001F

In partial-decode mode, only the two top address bits are compared, so each device appears again and again across the unused space. This takes less logic, but the map is no longer exact.

Top module: `bus_chip_select`

## Requirements
- R1: While `as_n` is high, all bits of `cs_n` and all four byte strobes are high, whatever the address.
- R2: In full mode, `cs_n[1]` (RAM) is low exactly when address bits 23..17 equal 0100100, i.e. for $480000–$49FFFF. $47FFFE and $4A0000 select nothing.
- R3: In full mode, `cs_n[0]` (ROM) is low for $000000–$007FFF and `cs_n[2]` (I/O) is low for $800000–$80001F. $008000, $3FFFFE and $800020 select nothing.
- R4: In partial mode, address bits 23..22 equal to 00, 01 or 10 drive `cs_n[0]`, `cs_n[1]` or `cs_n[2]` low.
- R5: In partial mode, top bits 11 select nothing. Unused addresses alias onto the device named by their top bits: $3FFFFE gives ROM, $7FFFFE gives RAM, $800020 gives I/O.
- R6: At most one bit of `cs_n` is low at any time.
- R7: `upper_rd_n` is low exactly when some select is low, `uds_n` is low and `rw` is 1. `lower_rd_n` behaves the same way with `lds_n`.
- R8: `upper_wr_n` is low exactly when some select is low, `uds_n` is low and `rw` is 0. `lower_wr_n` behaves the same way with `lds_n`.
- R9: When no select is low, all four byte strobes are high, even with a data strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| as_n | input | 1 | Address strobe, active low |
| addr | input | 23 | Address lines 23..1 |
| uds_n | input | 1 | Upper byte data strobe, active low |
| lds_n | input | 1 | Lower byte data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| cs_n | output | 3 | Device selects, active low: bit 0 ROM, bit 1 RAM, bit 2 I/O |
| upper_rd_n | output | 1 | Upper byte read strobe, active low |
| lower_rd_n | output | 1 | Lower byte read strobe, active low |
| upper_wr_n | output | 1 | Upper byte write strobe, active low |
| lower_wr_n | output | 1 | Lower byte write strobe, active low |

## Verification
The assertions assume that the device windows given by the parameters do not overlap, because the one-select check relies on that. The defaults are disjoint. They also assume that the inputs are settled whenever the combinational process runs, so each check sees a consistent address, strobe and data-strobe set. The stimulus changes inputs only at whole time steps. It covers both edges of every window in both modes, the aliasing addresses and the top-bits-11 region, under read, write and single-lane strobe mixes. Each vector is sampled one time unit after it is applied.

// File: rtl/bus_chip_select.sv
module bus_chip_select #(
  parameter int AW = 24,
  parameter int NDEV = 3,
  parameter int SPW = 5,
  parameter int TOP_BITS = 2,
  parameter bit FULL_DECODE = 1'b1,
  parameter logic [NDEV*AW-1:0] DEV_BASE = {24'h800000, 24'h480000, 24'h000000},
  parameter logic [NDEV*SPW-1:0] DEV_SPAN = {5'd5, 5'd17, 5'd15}
) (
  input  logic            as_n,
  input  logic [AW-1:1]   addr,
  input  logic            uds_n,
  input  logic            lds_n,
  input  logic            rw,
  output logic [NDEV-1:0] cs_n,
  output logic            upper_rd_n,
  output logic            lower_rd_n,
  output logic            upper_wr_n,
  output logic            lower_wr_n
);

  logic [NDEV-1:0] hit;

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    if (FULL_DECODE) begin : g_full
      localparam int SP = int'(DEV_SPAN[g*SPW +: SPW]);
      localparam logic [AW-1:0] BASE = DEV_BASE[g*AW +: AW];
      assign hit[g] = (addr[AW-1:SP] == BASE[AW-1:SP]);
    end else begin : g_part
      assign hit[g] = (addr[AW-1:AW-TOP_BITS] == TOP_BITS'(g));
    end
  end

  always_comb begin
    logic sel;
    cs_n = ~(hit & {NDEV{~as_n}});
    sel = ~&cs_n;
    upper_rd_n = ~(sel & ~uds_n & rw);
    lower_rd_n = ~(sel & ~lds_n & rw);
    upper_wr_n = ~(sel & ~uds_n & ~rw);
    lower_wr_n = ~(sel & ~lds_n & ~rw);

    // R1
    idle_cs_chk: assert (!as_n || (&cs_n && upper_rd_n && lower_rd_n && upper_wr_n && lower_wr_n));
    // R6
    one_sel_chk: assert ($onehot0(~cs_n));
    // R5
    top_unused_chk: assert (FULL_DECODE || !(&addr[AW-1:AW-TOP_BITS]) || &cs_n);
    // R9
    strobe_gate_chk: assert (!(&cs_n) || (upper_rd_n && lower_rd_n && upper_wr_n && lower_wr_n));
    // R8
    rd_wr_excl_chk: assert ((upper_rd_n && lower_rd_n) || (upper_wr_n && lower_wr_n));
  end

endmodule

// File: tb/tb_bus_chip_select.sv
module tb_bus_chip_select;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
  logic [23:0] a24 = '0;
  logic [2:0]  csf, csp;
  logic        urf, lrf, uwf, lwf, urp, lrp, uwp, lwp;
  int checks = 0, errors = 0;

  bus_chip_select #(.FULL_DECODE(1'b1)) dut (
    .as_n(as_n), .addr(a24[23:1]), .uds_n(uds_n), .lds_n(lds_n), .rw(rw),
    .cs_n(csf), .upper_rd_n(urf), .lower_rd_n(lrf), .upper_wr_n(uwf), .lower_wr_n(lwf));

  bus_chip_select #(.FULL_DECODE(1'b0)) dut_part (
    .as_n(as_n), .addr(a24[23:1]), .uds_n(uds_n), .lds_n(lds_n), .rw(rw),
    .cs_n(csp), .upper_rd_n(urp), .lower_rd_n(lrp), .upper_wr_n(uwp), .lower_wr_n(lwp));

  // addr, as_n, uds_n, lds_n, rw, expected full cs_n, expected partial cs_n
  localparam int NV = 20;
  localparam logic [33:0] TBL [NV] = '{
    {24'h480000, 1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 3'b111},
    {24'h000000, 1'b1, 1'b0, 1'b1, 1'b0, 3'b111, 3'b111},
    {24'h480000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b101, 3'b101},
    {24'h49FFFE, 1'b0, 1'b0, 1'b1, 1'b0, 3'b101, 3'b101},
    {24'h47FFFE, 1'b0, 1'b1, 1'b0, 1'b1, 3'b111, 3'b101},
    {24'h4A0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 3'b101},
    {24'h000000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b110, 3'b110},
    {24'h007FFE, 1'b0, 1'b1, 1'b0, 1'b0, 3'b110, 3'b110},
    {24'h008000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 3'b110},
    {24'h3FFFFE, 1'b0, 1'b0, 1'b1, 1'b1, 3'b111, 3'b110},
    {24'h800000, 1'b0, 1'b0, 1'b0, 1'b0, 3'b011, 3'b011},
    {24'h80001E, 1'b0, 1'b0, 1'b1, 1'b1, 3'b011, 3'b011},
    {24'h800020, 1'b0, 1'b1, 1'b0, 1'b0, 3'b111, 3'b011},
    {24'hC00000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 3'b111},
    {24'hFFFFFE, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 3'b111},
    {24'h7FFFFE, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 3'b101},
    {24'h420000, 1'b0, 1'b1, 1'b1, 1'b1, 3'b111, 3'b101},
    {24'h480000, 1'b0, 1'b1, 1'b1, 1'b0, 3'b101, 3'b101},
    {24'h80001E, 1'b1, 1'b0, 1'b0, 1'b0, 3'b111, 3'b111},
    {24'h400000, 1'b0, 1'b0, 1'b1, 1'b0, 3'b111, 3'b101}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h as_n=%b uds_n=%b lds_n=%b rw=%b act=%b exp=%b",
               req, a24, as_n, uds_n, lds_n, rw, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes(input logic [2:0] cs, input logic u, input logic l, input logic r);
    logic s;
    s = (cs != 3'b111);
    return {~(s & ~u & r), ~(s & ~l & r), ~(s & ~u & ~r), ~(s & ~l & ~r)};
  endfunction

  task automatic apply_check(input logic [33:0] v, input string tag);
    {a24, as_n, uds_n, lds_n, rw} = v[33:6];
    #1;
    // R2 R3 R1: full-mode selects
    chk({tag, " R2/R3 full cs"}, {5'b0, csf}, {5'b0, v[5:3]});
    // R4 R5: partial-mode selects
    chk({tag, " R4/R5 part cs"}, {5'b0, csp}, {5'b0, v[2:0]});
    // R7 R8 R9: byte strobes
    chk({tag, " R7/R8/R9 full strobes"}, {4'b0, urf, lrf, uwf, lwf},
        {4'b0, strobes(v[5:3], uds_n, lds_n, rw)});
    chk({tag, " R7/R8/R9 part strobes"}, {4'b0, urp, lrp, uwp, lwp},
        {4'b0, strobes(v[2:0], uds_n, lds_n, rw)});
    // R6
    chk({tag, " R6 onehot"}, {7'b0, ($countones(~csf) <= 1) && ($countones(~csp) <= 1)}, 8'd1);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: idle state, strobe high
    #1;
    chk("R1 idle full cs", {5'b0, csf}, 8'h07);
    chk("R1 idle part cs", {5'b0, csp}, 8'h07);
    chk("R1 idle strobes", {urf, lrf, uwf, lwf, urp, lrp, uwp, lwp}, 8'hFF);
    @(negedge clk);
    for (int i = 0; i < NV; i++) apply_check(TBL[i], "vec");
    // R7: upper-only read on the RAM
    apply_check({24'h480002, 1'b0, 1'b0, 1'b1, 1'b1, 3'b101, 3'b101}, "R7 upper rd");
    // R8: lower-only write on the I/O
    apply_check({24'h800010, 1'b0, 1'b1, 1'b0, 1'b0, 3'b011, 3'b011}, "R8 lower wr");
    // R9: data strobes low, no device
    apply_check({24'hE00000, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111, 3'b111}, "R9 no dev");
    // R1: strobe returns high mid-transfer
    apply_check({24'h000010, 1'b1, 1'b0, 1'b0, 1'b0, 3'b111, 3'b111}, "R1 release");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule